// File: doc/BRIEF.md
# Bus Loopback and Idle-Gating Controller

This block sits between a serial link controller and the bus line. It picks the source of the controller's digital receive input. In normal running that source is the bus. Under a digital self-test it is the controller's own transmit output. Under an external transceiver loopback the transmitter's final drive signal is reflected back, and the bus is left undriven.

The block also decides when the link controller may receive and may transmit. After reset, and each time the transceiver loopback is released, both permissions are withdrawn. Reception returns once the bus has stayed quiet for one end-of-frame time. Transmission returns once the bus has stayed quiet for one inter-frame time. Any active level on the bus during the wait starts the quiet count again from zero.

A fast receive-only mode shortens both quiet times to a quarter of their normal length and blocks transmission completely. Bit coding and CRC are handled elsewhere. Time is measured with a one-cycle microsecond tick.

Top module: `lbk_idle_gate`

## Requirements
- R1: While `digLoop` is 1, `rxLine` equals `txOut`. While both `digLoop` and `anaLoop` are 0, `rxLine` equals `busIn`. The path is combinational.
- R2: While `anaLoop` is 1, `rxLine` equals `txOut` and `driveEn` is 0. The quiet count is held at zero. `rxAllowed` is 1, and `txAllowed` is 1 unless `rx4x` is 1.
- R3: After reset, or after `anaLoop` falls, `rxAllowed` is 0 until the quiet count reaches the end-of-frame threshold. That threshold is 280 ticks, or 70 ticks when `rx4x` is 1. `rxAllowed` then rises one clock later and stays 1 until `anaLoop` is set again, whatever the bus does in the meantime.
- R4: After reset, or after `anaLoop` falls, the transmit gate opens one clock after the quiet count reaches the inter-frame threshold. That threshold is 300 ticks, or 75 ticks when `rx4x` is 1. The gate stays open until `anaLoop` is set again.
- R5: While `rx4x` is 1, `txAllowed` is 0 and `driveEn` is 0.
- R6: The bus active level is 1. A 1 on `busIn` reaches the idle logic through a two-stage synchronizer and clears the quiet count to zero. The count advances by one on each clock where `usTick` is 1 and the synchronized bus is 0. It saturates at the inter-frame threshold.
- R7: `driveEn` is 1 exactly when `txAllowed` is 1 and both `anaLoop` and `digLoop` are 0.
- R8: During and straight after reset, with `anaLoop` at 0, `rxAllowed`, `txAllowed` and `driveEn` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| digLoop | input | 1 | Digital loopback select |
| anaLoop | input | 1 | Transceiver loopback select; bus not driven |
| rx4x | input | 1 | Fast receive-only mode |
| usTick | input | 1 | One-cycle pulse every microsecond |
| busIn | input | 1 | Raw bus line, 1 = active |
| txOut | input | 1 | Link controller transmit output |
| rxLine | output | 1 | Selected receive input for the link controller |
| driveEn | output | 1 | Bus driver enable |
| rxAllowed | output | 1 | Reception permitted |
| txAllowed | output | 1 | Transmission permitted |

## Verification
The bench measures how many ticks pass between releasing the loopback and each gate opening. A design that compared against the wrong threshold, or opened the gate one clock early or late, shows up as a count other than 280, 300, 70 or 75.

A single bus pulse is injected midway through the wait. A design that only paused the count, rather than restarting it, would let reception open about 150 ticks too soon.

Fast mode is held for longer than the inter-frame time. A design that only rescaled the thresholds would open the transmit gate, where the correct design keeps it shut.

A long random stretch toggles every control input against a behavioural model. It catches a receive gate that closes on later bus activity, and a drive enable that leaks out during a loopback.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic clrIdle;   // restart the quiet-time count from zero
    logic stepIdle;  // advance the quiet-time count by one microsecond
  } lbkStrobe_t;

  // Status returned by the datapath half to the control half.
  typedef struct packed {
    logic busActive;   // synchronized bus level is active
    logic eofReached;  // quiet count has reached the end-of-frame threshold
    logic ifsReached;  // quiet count has reached the inter-frame threshold
    logic cntSat;      // quiet count at its saturation value
  } lbkFlags_t;

endpackage

// File: rtl/lbk_datapath.sv
module lbk_datapath
  import lbk_pkg::*;
#(
  parameter int EOF_US      = 280,
  parameter int IFS_US      = 300,
  parameter int SPEED_DIV   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busIn,
  input  logic       txOut,
  input  logic       loopSel,
  input  logic       fastMode,
  input  lbkStrobe_t strobe,
  output logic       rxLine,
  output lbkFlags_t  flags
);

  localparam int CNT_W    = $clog2(IFS_US + 1);
  localparam int EOF_FAST = EOF_US / SPEED_DIV;
  localparam int IFS_FAST = IFS_US / SPEED_DIV;

  localparam logic [CNT_W-1:0] EOF_SLOW_T = CNT_W'(EOF_US);
  localparam logic [CNT_W-1:0] IFS_SLOW_T = CNT_W'(IFS_US);
  localparam logic [CNT_W-1:0] EOF_FAST_T = CNT_W'(EOF_FAST);
  localparam logic [CNT_W-1:0] IFS_FAST_T = CNT_W'(IFS_FAST);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       idleCnt;
  logic [CNT_W-1:0]       eofThr;
  logic [CNT_W-1:0]       ifsThr;

  // Receive source select: the raw bus or the local transmit output.
  assign rxLine = loopSel ? txOut : busIn;

  // Bus level synchronizer for the idle measurement.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= busIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], busIn};
      end
    end
  endgenerate

  // Thresholds follow the current speed mode.
  assign eofThr = fastMode ? EOF_FAST_T : EOF_SLOW_T;
  assign ifsThr = fastMode ? IFS_FAST_T : IFS_SLOW_T;

  // Quiet-time counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobe.clrIdle) begin
      idleCnt <= '0;
    end else if (strobe.stepIdle) begin
      idleCnt <= idleCnt + CNT_W'(1);
    end
  end

  assign flags.busActive  = syncQ[SYNC_STAGES-1];
  assign flags.eofReached = (idleCnt >= eofThr);
  assign flags.ifsReached = (idleCnt >= ifsThr);
  assign flags.cntSat     = (idleCnt >= IFS_SLOW_T);

endmodule

// File: rtl/lbk_control.sv
module lbk_control
  import lbk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       digLoop,
  input  logic       anaLoop,
  input  logic       rx4x,
  input  logic       usTick,
  input  lbkFlags_t  flags,
  output lbkStrobe_t strobe,
  output logic       loopSel,
  output logic       rxAllowed,
  output logic       txAllowed,
  output logic       driveEn
);

  logic rxOpen;
  logic txOpen;

  // Any loopback feeds the transmit path back to the receiver.
  assign loopSel = digLoop | anaLoop;

  // A transceiver loopback or an active bus restarts the quiet time.
  assign strobe.clrIdle  = anaLoop | flags.busActive;
  assign strobe.stepIdle = usTick & ~flags.cntSat;

  // Gates latch open once their threshold is met; loopback closes them.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOpen <= 1'b0;
      txOpen <= 1'b0;
    end else if (anaLoop) begin
      rxOpen <= 1'b0;
      txOpen <= 1'b0;
    end else begin
      if (flags.eofReached) rxOpen <= 1'b1;
      if (flags.ifsReached) txOpen <= 1'b1;
    end
  end

  assign rxAllowed = anaLoop | rxOpen;
  assign txAllowed = (anaLoop | txOpen) & ~rx4x;
  assign driveEn   = txAllowed & ~anaLoop & ~digLoop;

endmodule

// File: rtl/lbk_idle_gate.sv
module lbk_idle_gate
  import lbk_pkg::*;
#(
  parameter int EOF_US      = 280,
  parameter int IFS_US      = 300,
  parameter int SPEED_DIV   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic digLoop,
  input  logic anaLoop,
  input  logic rx4x,
  input  logic usTick,
  input  logic busIn,
  input  logic txOut,
  output logic rxLine,
  output logic driveEn,
  output logic rxAllowed,
  output logic txAllowed
);

  lbkStrobe_t strobe;
  lbkFlags_t  flags;
  logic       loopSel;

  lbk_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .digLoop   (digLoop),
    .anaLoop   (anaLoop),
    .rx4x      (rx4x),
    .usTick    (usTick),
    .flags     (flags),
    .strobe    (strobe),
    .loopSel   (loopSel),
    .rxAllowed (rxAllowed),
    .txAllowed (txAllowed),
    .driveEn   (driveEn)
  );

  lbk_datapath #(
    .EOF_US      (EOF_US),
    .IFS_US      (IFS_US),
    .SPEED_DIV   (SPEED_DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busIn    (busIn),
    .txOut    (txOut),
    .loopSel  (loopSel),
    .fastMode (rx4x),
    .strobe   (strobe),
    .rxLine   (rxLine),
    .flags    (flags)
  );

endmodule

// File: rtl/lbk_idle_gate_chk.sv
module lbk_idle_gate_chk (
  input logic clk,
  input logic rstN,
  input logic digLoop,
  input logic anaLoop,
  input logic rx4x,
  input logic txOut,
  input logic rxLine,
  input logic driveEn,
  input logic rxAllowed,
  input logic txAllowed
);

  AST_DIGLOOP_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    digLoop |-> (rxLine == txOut)); // R1

  AST_ANALOG_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    anaLoop |-> (!driveEn && rxAllowed)); // R2

  AST_RX_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxAllowed && !anaLoop) && !anaLoop) |-> rxAllowed); // R3

  AST_TX_AFTER_RX: assert property (@(posedge clk) disable iff (!rstN)
    (txAllowed && !anaLoop) |-> rxAllowed); // R4

  AST_FAST_NO_TX: assert property (@(posedge clk) disable iff (!rstN)
    rx4x |-> (!txAllowed && !driveEn)); // R5

  AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> (txAllowed && !digLoop)); // R7

endmodule

bind lbk_idle_gate lbk_idle_gate_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .digLoop   (digLoop),
  .anaLoop   (anaLoop),
  .rx4x      (rx4x),
  .txOut     (txOut),
  .rxLine    (rxLine),
  .driveEn   (driveEn),
  .rxAllowed (rxAllowed),
  .txAllowed (txAllowed)
);

// File: tb/lbk_idle_gate_tb.sv
module lbk_idle_gate_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic digLoop = 1'b0, anaLoop = 1'b0, rx4x = 1'b0;
  logic usTick = 1'b0, busIn = 1'b0, txOut = 1'b0;
  logic rxLine, driveEn, rxAllowed, txAllowed;

  int checks = 0;
  int errors = 0;
  bit autoTick = 1'b1;
  int tickDiv = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  bit mRxOpen = 0, mTxOpen = 0, mS0 = 0, mS1 = 0;
  int mCnt = 0;

  always #10 clk = ~clk;

  lbk_idle_gate u_dut (
    .clk(clk), .rstN(rstN), .digLoop(digLoop), .anaLoop(anaLoop),
    .rx4x(rx4x), .usTick(usTick), .busIn(busIn), .txOut(txOut),
    .rxLine(rxLine), .driveEn(driveEn), .rxAllowed(rxAllowed),
    .txAllowed(txAllowed)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRxOpen = 0; mTxOpen = 0; mCnt = 0; mS0 = 0; mS1 = 0;
    end else begin
      int eofT, ifsT;
      bit busy;
      eofT = rx4x ? 70 : 280;
      ifsT = rx4x ? 75 : 300;
      busy = mS1;
      if (anaLoop) begin
        mRxOpen = 0; mTxOpen = 0;
      end else begin
        if (mCnt >= eofT) mRxOpen = 1;
        if (mCnt >= ifsT) mTxOpen = 1;
      end
      if (anaLoop || busy) mCnt = 0;
      else if (usTick && mCnt < 300) mCnt = mCnt + 1;
      mS1 = mS0;
      mS0 = busIn;
    end
  end

  task automatic chk(input bit got, input bit exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit eRx, eTx, eDrv, eLine;
    eRx   = anaLoop | mRxOpen;
    eTx   = (anaLoop | mTxOpen) & ~rx4x;
    eDrv  = eTx & ~anaLoop & ~digLoop;
    eLine = (digLoop | anaLoop) ? txOut : busIn;
    chk(rxLine,    eLine, (digLoop && !anaLoop) ? "R1" : (anaLoop ? "R2" : "R1"), "rxLine");
    chk(rxAllowed, eRx,   "R3", "rxAllowed");
    chk(txAllowed, eTx,   rx4x ? "R5" : "R4", "txAllowed");
    chk(driveEn,   eDrv,  "R7", "driveEn");
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
    usTick = autoTick && (tickDiv == 0);
    tickDiv = (tickDiv + 1) % 3;
  endtask

  // Release the transceiver loopback and measure ticks until each gate opens.
  task automatic releaseRun(input int cycles, input int pulseAt,
                            output int rxTicks, output int txTicks);
    int ticks;
    bit pulsed;
    rxTicks = -1; txTicks = -1; pulsed = 0;
    step();
    anaLoop = 1'b0;
    ticks = usTick;
    for (int i = 0; i < cycles; i++) begin
      step();
      busIn = 1'b0;
      if (rxAllowed && rxTicks < 0) rxTicks = ticks;
      if (txAllowed && txTicks < 0) txTicks = ticks;
      if (!pulsed && pulseAt >= 0 && ticks >= pulseAt) begin
        busIn = 1'b1;
        pulsed = 1;
      end
      ticks += usTick;
    end
  endtask

  task automatic loopPulse();
    anaLoop = 1'b1;
    repeat (6) begin
      step();
      txOut = ~txOut;
      // R2: loopback reflects the transmit output, no bus drive
    end
  endtask

  initial begin
    int rxT, txT;
    // R8: reset state
    repeat (3) step();
    checks++;
    if (rxAllowed !== 0 || txAllowed !== 0 || driveEn !== 0) begin
      errors++;
      $display("FAIL R8 reset gates actual=%0b%0b%0b expected=000", rxAllowed, txAllowed, driveEn);
    end
    rstN = 1'b1;
    step();
    chk(rxAllowed, 1'b0, "R8", "rxAllowed after reset");

    // R1: bus passes through, then digital loopback echoes txOut
    busIn = 1'b1; txOut = 1'b0;
    step(); chk(rxLine, 1'b1, "R1", "rxLine from bus");
    digLoop = 1'b1;
    step(); chk(rxLine, 1'b0, "R1", "rxLine from txOut");
    digLoop = 1'b0; busIn = 1'b0;

    // R3 R4: normal speed thresholds after loopback release
    loopPulse();
    releaseRun(1100, -1, rxT, txT);
    checks++;
    if (rxT != 280) begin errors++; $display("FAIL R3 rx ticks actual=%0d expected=280", rxT); end
    checks++;
    if (txT != 300) begin errors++; $display("FAIL R4 tx ticks actual=%0d expected=300", txT); end
    chk(driveEn, 1'b1, "R7", "drive after open");
    // R3: bus activity after opening does not close gates
    busIn = 1'b1; repeat (5) step(); busIn = 1'b0; step();
    chk(rxAllowed, 1'b1, "R3", "rx latched open");

    // R6: a bus pulse midway restarts the quiet count
    loopPulse();
    releaseRun(1500, 150, rxT, txT);
    checks++;
    if (rxT <= 420) begin errors++; $display("FAIL R6 rx ticks actual=%0d expected>420", rxT); end

    // R5: fast receive-only mode
    loopPulse();
    rx4x = 1'b1;
    releaseRun(1200, -1, rxT, txT);
    checks++;
    if (rxT != 70) begin errors++; $display("FAIL R5 rx ticks actual=%0d expected=70", rxT); end
    checks++;
    if (txT != -1) begin errors++; $display("FAIL R5 tx opened actual=%0d expected=-1", txT); end
    rx4x = 1'b0;
    step();
    chk(txAllowed, 1'b1, "R4", "tx after leaving fast mode");
    // R7: digital loopback blocks drive
    digLoop = 1'b1; step(); chk(driveEn, 1'b0, "R7", "drive in digital loop");
    digLoop = 1'b0;

    // Random stretch compared against the model every cycle
    for (int i = 0; i < 30000; i++) begin
      step();
      txOut = $urandom_range(0, 1);
      if ($urandom_range(0, 399) == 0) anaLoop = ~anaLoop;
      if ($urandom_range(0, 799) == 0) rx4x = ~rx4x;
      if ($urandom_range(0, 99) == 0) digLoop = ~digLoop;
      busIn = ($urandom_range(0, 1499) == 0);
    end
    step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule